// File: doc/BRIEF.md
# Scaled Displacement Load/Store Unit

This unit carries out one register-plus-offset memory access per request. The caller supplies a 4-bit operation code, a 32-bit base value, a 12-bit unsigned displacement and, for stores, the source data. The unit decodes the access size, multiplies the displacement by that size and adds it to the base. It then drives a single data-width memory port, holding the request until the memory answers with ready. Data sits on the byte lanes in big-endian order.

A store ends after the memory has accepted it. A load returns the addressed byte, halfword or word as a 32-bit result. The operation code decides whether a short value is sign- or zero-extended. An operation code the unit cannot execute, or a misaligned address, produces a fault code instead of a memory access. Every request, legal or not, ends with exactly one single-cycle response.

Top module: `disp_ldst_unit`

## Requirements
- R1: The operation code selects the access. Stores: 0 byte, 1 halfword, 2 word. Signed loads: 4 byte, 5 halfword. Load word: 6. Unsigned loads: 8 byte, 9 halfword. The address is base + displacement x (1, 2 or 4 for byte, halfword, word), with the 12-bit displacement zero-extended and the sum taken modulo 2^32.
- R2: `mem_be` bit 3 selects data bits 31:24, which hold the byte at address offset 0, and bit 0 selects bits 7:0 at offset 3. A byte access enables one lane, a halfword two, a word all four. A store places its data on the enabled lanes, most significant byte at the lowest address, with the other lanes zero. Loads drive `mem_wdata` as zero.
- R3: Operations 4 and 5 sign-extend the loaded byte or halfword to 32 bits.
- R4: Operations 8 and 9 zero-extend the loaded byte or halfword. Operation 6 returns the whole word. `rsp_data` is zero for stores and faulted requests.
- R5: A halfword access at an odd address, or a word access at an address that is not a multiple of 4, returns fault code 3 and makes no memory access. Byte accesses are never misaligned.
- R6: Operations 3 and 7 (floating-point transfers) return fault code 2 and make no memory access. This takes priority over the alignment check.
- R7: Operations 10 to 15 return fault code 1 and make no memory access. This also takes priority over the alignment check. Fault code 0 means success.
- R8: A request is accepted when `req_valid` and `req_ready` are both high. `req_ready` is high only while the unit is idle, and `req_valid` is ignored at all other times. `mem_req` holds with stable address, enables, data and write flag until `mem_ready`. `rsp_valid` pulses for one cycle in the cycle after the edge at which `mem_ready` is sampled high. A faulted request responds in the cycle after acceptance.
- R9: During and right after reset, `mem_req`, `mem_be` and `rsp_valid` are low, and `req_ready` is high once reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle, request taken this cycle |
| req_op | input | 4 | Operation code |
| req_base | input | ADDR_W | Base address value |
| req_disp | input | DISP_W | Unsigned displacement |
| req_wdata | input | 32 | Store source data |
| mem_req | output | 1 | Memory access pending |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | ADDR_W | Byte address of the access |
| mem_be | output | DATA_W/8 | Lane enables |
| mem_wdata | output | DATA_W | Write data on lanes |
| mem_rdata | input | DATA_W | Read data from memory |
| mem_ready | input | 1 | Memory completes the access |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_fault | output | 2 | Fault code |
| rsp_data | output | 32 | Extended load result |

## Verification
A wrongly latched lane offset or size appears at once, in the first cycle of `mem_req`, as wrong enables or misplaced store bytes. A wrong extension or lane pick for a load appears on `rsp_data` one cycle after the ready edge. A sequencer that loses its state shows up in one of three ways: `mem_req` never drops, a faulted request reaches the memory, or a request raised while the unit is busy produces a second response that matches no issued request. The scoreboard compares each access and each response against a model built from the requirements, so any of these is flagged in the cycle it occurs.

// File: rtl/disp_lsu_pkg.sv
package disp_lsu_pkg;

   localparam int ACC_W = 32;

   typedef enum logic [1:0] {
      SZ_8  = 2'd0,
      SZ_16 = 2'd1,
      SZ_32 = 2'd2
   } acc_size_e;

   typedef enum logic [1:0] {
      FLT_NONE  = 2'd0,
      FLT_UNDEF = 2'd1,
      FLT_FPU   = 2'd2,
      FLT_ALIGN = 2'd3
   } fault_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_MEM  = 2'd1,
      ST_RSP  = 2'd2
   } fsm_e;

   typedef struct packed {
      logic      is_store;
      logic      sext;
      acc_size_e size;
      fault_e    fault;
   } op_info_t;

   localparam logic [3:0] OP_ST8   = 4'd0;
   localparam logic [3:0] OP_ST16  = 4'd1;
   localparam logic [3:0] OP_ST32  = 4'd2;
   localparam logic [3:0] OP_FST   = 4'd3;
   localparam logic [3:0] OP_LD8   = 4'd4;
   localparam logic [3:0] OP_LD16  = 4'd5;
   localparam logic [3:0] OP_LD32  = 4'd6;
   localparam logic [3:0] OP_FLD   = 4'd7;
   localparam logic [3:0] OP_LDU8  = 4'd8;
   localparam logic [3:0] OP_LDU16 = 4'd9;

endpackage

// File: rtl/disp_lsu_decode.sv
module disp_lsu_decode
   import disp_lsu_pkg::*;
(
   input  logic [3:0] op,
   output op_info_t   info
);

   always_comb begin
      info          = '0;
      info.size     = SZ_8;
      info.fault    = FLT_NONE;
      case (op)
         OP_ST8: begin
            info.is_store = 1'b1;
            info.size     = SZ_8;
         end
         OP_ST16: begin
            info.is_store = 1'b1;
            info.size     = SZ_16;
         end
         OP_ST32: begin
            info.is_store = 1'b1;
            info.size     = SZ_32;
         end
         OP_LD8: begin
            info.sext = 1'b1;
            info.size = SZ_8;
         end
         OP_LD16: begin
            info.sext = 1'b1;
            info.size = SZ_16;
         end
         OP_LD32: begin
            info.size = SZ_32;
         end
         OP_LDU8: begin
            info.size = SZ_8;
         end
         OP_LDU16: begin
            info.size = SZ_16;
         end
         OP_FST, OP_FLD: begin
            info.fault = FLT_FPU;
         end
         default: begin
            info.fault = FLT_UNDEF;
         end
      endcase
   end

endmodule

// File: rtl/disp_lsu_agen.sv
module disp_lsu_agen
   import disp_lsu_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int DISP_W     = 12,
   parameter int DATA_W     = 32,
   parameter bit BIG_ENDIAN = 1'b1
)(
   input  logic [ADDR_W-1:0]   base,
   input  logic [DISP_W-1:0]   disp,
   input  acc_size_e           size,
   input  logic                is_store,
   input  logic [ACC_W-1:0]    st_data,
   output logic [ADDR_W-1:0]   ea,
   output logic                misaligned,
   output logic [DATA_W/8-1:0] be,
   output logic [DATA_W-1:0]   lanes
);

   localparam int NBYTES = DATA_W / 8;
   localparam int OFF_W  = $clog2(NBYTES);

   logic [ADDR_W-1:0] disp_ext;
   logic [OFF_W-1:0]  off;
   logic [OFF_W:0]    nbytes;

   assign disp_ext = {{(ADDR_W-DISP_W){1'b0}}, disp};
   assign ea       = base + (disp_ext << size);
   assign off      = ea[OFF_W-1:0];

   always_comb begin
      case (size)
         SZ_8:    nbytes = (OFF_W+1)'(1);
         SZ_16:   nbytes = (OFF_W+1)'(2);
         default: nbytes = (OFF_W+1)'(4);
      endcase
   end

   assign misaligned = ((size == SZ_16) && ea[0]) ||
                       ((size == SZ_32) && (ea[1:0] != 2'b00));

   for (genvar j = 0; j < NBYTES; j++) begin : g_lane
      localparam int             MOFF_I = BIG_ENDIAN ? (NBYTES - 1 - j) : j;
      localparam logic [OFF_W:0] MOFF   = MOFF_I[OFF_W:0];

      logic [OFF_W:0] rel;
      logic [OFF_W:0] rev;
      logic           hit;
      logic [1:0]     bidx;

      assign rel  = MOFF - {1'b0, off};
      assign rev  = nbytes - rel - (OFF_W+1)'(1);
      assign hit  = (MOFF >= {1'b0, off}) && (rel < nbytes);
      assign bidx = BIG_ENDIAN ? rev[1:0] : rel[1:0];

      assign be[j]          = hit;
      assign lanes[j*8 +: 8] = (hit && is_store) ? st_data[{bidx, 3'b000} +: 8] : 8'h00;
   end

endmodule

// File: rtl/disp_lsu_extract.sv
module disp_lsu_extract
   import disp_lsu_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter bit BIG_ENDIAN = 1'b1,
   localparam int NBYTES    = DATA_W / 8,
   localparam int OFF_W     = $clog2(NBYTES)
)(
   input  logic [DATA_W-1:0] rdata,
   input  logic [OFF_W-1:0]  off,
   input  acc_size_e         size,
   input  logic              sext,
   output logic [ACC_W-1:0]  result
);

   logic [7:0] acc_b [4];

   for (genvar i = 0; i < 4; i++) begin : g_pick
      logic [OFF_W-1:0] moff;
      logic [OFF_W-1:0] lane;
      assign moff     = off + OFF_W'(i);
      assign lane     = BIG_ENDIAN ? (OFF_W'(NBYTES - 1) - moff) : moff;
      assign acc_b[i] = rdata[{lane, 3'b000} +: 8];
   end

   logic [15:0] half;

   always_comb begin
      half = BIG_ENDIAN ? {acc_b[0], acc_b[1]} : {acc_b[1], acc_b[0]};
      case (size)
         SZ_8:    result = sext ? {{24{acc_b[0][7]}}, acc_b[0]} : {24'h000000, acc_b[0]};
         SZ_16:   result = sext ? {{16{half[15]}}, half} : {16'h0000, half};
         default: result = BIG_ENDIAN ? {acc_b[0], acc_b[1], acc_b[2], acc_b[3]}
                                      : {acc_b[3], acc_b[2], acc_b[1], acc_b[0]};
      endcase
   end

endmodule

// File: rtl/disp_ldst_unit.sv
module disp_ldst_unit
   import disp_lsu_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int DISP_W     = 12,
   parameter int DATA_W     = 32,
   parameter bit BIG_ENDIAN = 1'b1
)(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   output logic                req_ready,
   input  logic [3:0]          req_op,
   input  logic [ADDR_W-1:0]   req_base,
   input  logic [DISP_W-1:0]   req_disp,
   input  logic [31:0]         req_wdata,
   output logic                mem_req,
   output logic                mem_we,
   output logic [ADDR_W-1:0]   mem_addr,
   output logic [DATA_W/8-1:0] mem_be,
   output logic [DATA_W-1:0]   mem_wdata,
   input  logic [DATA_W-1:0]   mem_rdata,
   input  logic                mem_ready,
   output logic                rsp_valid,
   output logic [1:0]          rsp_fault,
   output logic [31:0]         rsp_data
);

   localparam int NBYTES = DATA_W / 8;
   localparam int OFF_W  = $clog2(NBYTES);

   if (DATA_W != 32 && DATA_W != 64) begin : g_bad_data_w
      $error("disp_ldst_unit: DATA_W must be 32 or 64");
   end
   if (DISP_W < 1 || DISP_W + 2 >= ADDR_W) begin : g_bad_disp_w
      $error("disp_ldst_unit: DISP_W must be at least 1 and leave room for scaling");
   end
   if (ADDR_W < 8 || ADDR_W > 64) begin : g_bad_addr_w
      $error("disp_ldst_unit: ADDR_W out of range");
   end

   op_info_t            info;
   logic [ADDR_W-1:0]   ea;
   logic                mis;
   logic [NBYTES-1:0]   be_n;
   logic [DATA_W-1:0]   lanes_n;
   logic [31:0]         ld_val;
   fault_e              acc_fault;

   fsm_e                state_q;
   logic [ADDR_W-1:0]   addr_q;
   logic [NBYTES-1:0]   be_q;
   logic [DATA_W-1:0]   wdata_q;
   logic                we_q;
   acc_size_e           size_q;
   logic                sext_q;
   fault_e              fault_q;
   logic [31:0]         data_q;

   disp_lsu_decode u_dec (
      .op   (req_op),
      .info (info)
   );

   disp_lsu_agen #(
      .ADDR_W     (ADDR_W),
      .DISP_W     (DISP_W),
      .DATA_W     (DATA_W),
      .BIG_ENDIAN (BIG_ENDIAN)
   ) u_agen (
      .base       (req_base),
      .disp       (req_disp),
      .size       (info.size),
      .is_store   (info.is_store),
      .st_data    (req_wdata),
      .ea         (ea),
      .misaligned (mis),
      .be         (be_n),
      .lanes      (lanes_n)
   );

   disp_lsu_extract #(
      .DATA_W     (DATA_W),
      .BIG_ENDIAN (BIG_ENDIAN)
   ) u_ext (
      .rdata  (mem_rdata),
      .off    (addr_q[OFF_W-1:0]),
      .size   (size_q),
      .sext   (sext_q),
      .result (ld_val)
   );

   always_comb begin
      acc_fault = info.fault;
      if (info.fault == FLT_NONE && mis) begin
         acc_fault = FLT_ALIGN;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         addr_q  <= '0;
         be_q    <= '0;
         wdata_q <= '0;
         we_q    <= 1'b0;
         size_q  <= SZ_8;
         sext_q  <= 1'b0;
         fault_q <= FLT_NONE;
         data_q  <= '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (req_valid) begin
                  fault_q <= acc_fault;
                  data_q  <= '0;
                  if (acc_fault != FLT_NONE) begin
                     state_q <= ST_RSP;
                  end else begin
                     state_q <= ST_MEM;
                     addr_q  <= ea;
                     be_q    <= be_n;
                     wdata_q <= lanes_n;
                     we_q    <= info.is_store;
                     size_q  <= info.size;
                     sext_q  <= info.sext;
                  end
               end
            end
            ST_MEM: begin
               if (mem_ready) begin
                  state_q <= ST_RSP;
                  data_q  <= we_q ? 32'h0 : ld_val;
               end
            end
            default: begin
               state_q <= ST_IDLE;
            end
         endcase
      end
   end

   assign req_ready = (state_q == ST_IDLE);
   assign mem_req   = (state_q == ST_MEM);
   assign mem_we    = mem_req & we_q;
   assign mem_be    = mem_req ? be_q : '0;
   assign mem_addr  = addr_q;
   assign mem_wdata = wdata_q;
   assign rsp_valid = (state_q == ST_RSP);
   assign rsp_fault = fault_q;
   assign rsp_data  = data_q;

endmodule

// File: rtl/disp_ldst_unit_chk.sv
module disp_ldst_unit_chk #(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32
)(
   input logic                clk,
   input logic                rst_n,
   input logic                req_ready,
   input logic                mem_req,
   input logic                mem_we,
   input logic [ADDR_W-1:0]   mem_addr,
   input logic [DATA_W/8-1:0] mem_be,
   input logic [DATA_W-1:0]   mem_wdata,
   input logic                mem_ready,
   input logic                rsp_valid,
   input logic [1:0]          rsp_fault
);

   assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_be)
                                && $stable(mem_wdata) && $stable(mem_we));

   assert_rsp_after_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_ready |=> rsp_valid && !mem_req);

   assert_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> !req_ready);

   assert_rsp_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

   assert_lane_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> ($countones(mem_be) == 1 || $countones(mem_be) == 2 ||
                   $countones(mem_be) == 4));

   assert_word_align_R5: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && $countones(mem_be) == 4 |-> mem_addr[1:0] == 2'b00);

   assert_half_align_R5: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && $countones(mem_be) == 2 |-> !mem_addr[0]);

   assert_fault_no_access_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && rsp_fault != 2'd0 |-> !$past(mem_req));

endmodule

bind disp_ldst_unit disp_ldst_unit_chk #(
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W)
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_ready (req_ready),
   .mem_req   (mem_req),
   .mem_we    (mem_we),
   .mem_addr  (mem_addr),
   .mem_be    (mem_be),
   .mem_wdata (mem_wdata),
   .mem_ready (mem_ready),
   .rsp_valid (rsp_valid),
   .rsp_fault (rsp_fault)
);

// File: tb/disp_ldst_unit_tb_top.sv
`timescale 1ns/1ps
module disp_ldst_unit_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [3:0]  req_op = 4'd0;
   logic [31:0] req_base = 32'd0;
   logic [11:0] req_disp = 12'd0;
   logic [31:0] req_wdata = 32'd0;
   logic        mem_req;
   logic        mem_we;
   logic [31:0] mem_addr;
   logic [3:0]  mem_be;
   logic [31:0] mem_wdata;
   logic [31:0] mem_rdata = 32'd0;
   logic        mem_ready = 1'b0;
   logic        rsp_valid;
   logic [1:0]  rsp_fault;
   logic [31:0] rsp_data;

   always #4 clk = ~clk;

   disp_ldst_unit dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_ready (req_ready),
      .req_op    (req_op),
      .req_base  (req_base),
      .req_disp  (req_disp),
      .req_wdata (req_wdata),
      .mem_req   (mem_req),
      .mem_we    (mem_we),
      .mem_addr  (mem_addr),
      .mem_be    (mem_be),
      .mem_wdata (mem_wdata),
      .mem_rdata (mem_rdata),
      .mem_ready (mem_ready),
      .rsp_valid (rsp_valid),
      .rsp_fault (rsp_fault),
      .rsp_data  (rsp_data)
   );

   typedef struct {
      logic [1:0]  fault;
      logic [31:0] addr;
      logic [3:0]  be;
      logic [31:0] wdata;
      logic        we;
      logic [31:0] data;
      string       tag;
   } exp_t;

   exp_t        exp_q[$];
   int          n_cmp = 0;
   int          n_bad = 0;
   int          n_issued = 0;
   int          n_rsp = 0;
   logic [31:0] mem_word = 32'd0;
   bit          seen_acc = 1'b0;
   int          wait_cnt = 0;
   int          acc_n = 0;

   task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] expv);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", what, act, expv);
      end
   endtask

   function automatic exp_t model(input logic [3:0] op, input logic [31:0] base,
                                  input logic [11:0] disp, input logic [31:0] sdata,
                                  input logic [31:0] mword, input string tag);
      exp_t        e;
      int          nb;
      int          k;
      int          sh;
      bit          st;
      bit          sg;
      logic [63:0] mask;
      logic [63:0] raw;
      e.fault = 2'd0; e.we = 1'b0; e.be = 4'd0; e.wdata = 32'd0; e.data = 32'd0; e.tag = tag;
      nb = 0; st = 1'b0; sg = 1'b0;
      case (op)
         4'd0: begin nb = 1; st = 1'b1; end
         4'd1: begin nb = 2; st = 1'b1; end
         4'd2: begin nb = 4; st = 1'b1; end
         4'd4: begin nb = 1; sg = 1'b1; end
         4'd5: begin nb = 2; sg = 1'b1; end
         4'd6: nb = 4;
         4'd8: nb = 1;
         4'd9: nb = 2;
         4'd3, 4'd7: e.fault = 2'd2;
         default: e.fault = 2'd1;
      endcase
      e.addr = base + 32'(disp) * 32'(nb);
      if (e.fault == 2'd0 && (e.addr & 32'(nb - 1)) != 32'd0) e.fault = 2'd3;
      if (e.fault == 2'd0) begin
         k    = int'(e.addr[1:0]);
         sh   = 8 * (4 - k - nb);
         mask = (64'd1 << (8 * nb)) - 64'd1;
         e.be = 4'(((1 << nb) - 1) << (4 - k - nb));
         e.we = st;
         if (st) begin
            e.wdata = 32'((64'(sdata) & mask) << sh);
         end else begin
            raw = (64'(mword) >> sh) & mask;
            if (sg && raw[8 * nb - 1]) raw = raw | ~mask;
            e.data = raw[31:0];
         end
      end
      return e;
   endfunction

   // memory responder with a varying wait count
   always @(negedge clk) begin
      if (mem_ready) begin
         mem_ready = 1'b0;
         acc_n++;
         wait_cnt = acc_n % 3;
      end else if (mem_req) begin
         if (wait_cnt == 0) begin
            mem_ready = 1'b1;
            mem_rdata = mem_word;
         end else begin
            wait_cnt--;
         end
      end
   end

   // monitor: compares accesses and responses against the queue
   always @(negedge clk) begin
      if (rst_n) begin
         if (mem_req && !seen_acc) begin
            seen_acc = 1'b1;
            if (exp_q.size() == 0) begin
               chk(1'b0, "R8 access with nothing outstanding", mem_addr, 32'd0);
            end else begin
               chk(exp_q[0].fault == 2'd0, {exp_q[0].tag, " (R5 R6 R7 no access on fault)"},
                   {30'd0, exp_q[0].fault}, 32'd0);
               chk(mem_addr == exp_q[0].addr, {exp_q[0].tag, " (R1 address)"}, mem_addr, exp_q[0].addr);
               chk(mem_be == exp_q[0].be, {exp_q[0].tag, " (R2 enables)"}, {28'd0, mem_be}, {28'd0, exp_q[0].be});
               chk(mem_wdata == exp_q[0].wdata, {exp_q[0].tag, " (R2 lanes)"}, mem_wdata, exp_q[0].wdata);
               chk(mem_we == exp_q[0].we, {exp_q[0].tag, " (R1 direction)"}, {31'd0, mem_we}, {31'd0, exp_q[0].we});
            end
         end
         if (rsp_valid) begin
            n_rsp++;
            if (exp_q.size() == 0) begin
               chk(1'b0, "R8 response with nothing outstanding", rsp_data, 32'd0);
            end else begin
               exp_t e;
               e = exp_q.pop_front();
               chk(rsp_fault == e.fault, {e.tag, " fault code"}, {30'd0, rsp_fault}, {30'd0, e.fault});
               chk(rsp_data == e.data, {e.tag, " result"}, rsp_data, e.data);
            end
            seen_acc = 1'b0;
         end
      end
   end

   task automatic issue(input logic [3:0] op, input logic [31:0] base, input logic [11:0] disp,
                        input logic [31:0] sdata, input logic [31:0] mword, input string tag);
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      exp_q.push_back(model(op, base, disp, sdata, mword, tag));
      mem_word  = mword;
      req_valid = 1'b1;
      req_op    = op;
      req_base  = base;
      req_disp  = disp;
      req_wdata = sdata;
      n_issued++;
      @(negedge clk);
      // R8: held request while busy must be ignored
      req_op   = 4'd2;
      req_base = ~base;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual %0d responses expected %0d", n_rsp, n_issued);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin : stimulus
      repeat (3) @(negedge clk);
      chk(mem_req == 1'b0, "R9 mem_req in reset", {31'd0, mem_req}, 32'd0);
      chk(mem_be == 4'd0, "R9 mem_be in reset", {28'd0, mem_be}, 32'd0);
      chk(rsp_valid == 1'b0, "R9 rsp_valid in reset", {31'd0, rsp_valid}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready == 1'b1, "R9 req_ready after reset", {31'd0, req_ready}, 32'd1);
      chk(mem_req == 1'b0, "R9 mem_req after reset", {31'd0, mem_req}, 32'd0);

      issue(4'd0, 32'h0000_1000, 12'h003, 32'h1234_56AB, 32'd0, "R1 R2 store byte offset 3");
      issue(4'd0, 32'h0000_1000, 12'h000, 32'h1234_56CD, 32'd0, "R1 R2 store byte offset 0");
      issue(4'd1, 32'h0000_2000, 12'h001, 32'hCAFE_BEEF, 32'd0, "R1 R2 store half x2 low lanes");
      issue(4'd1, 32'h0000_2000, 12'h000, 32'hCAFE_BEEF, 32'd0, "R1 R2 store half high lanes");
      issue(4'd2, 32'h0000_0100, 12'hFFF, 32'hDEAD_BEEF, 32'd0, "R1 R2 store word max disp x4");
      for (int k = 0; k < 4; k++)
         issue(4'd4, 32'h0000_3000, 12'(k), 32'd0, 32'h807F_01FE, "R3 signed byte load");
      for (int k = 0; k < 4; k++)
         issue(4'd8, 32'h0000_3000, 12'(k), 32'd0, 32'h807F_01FE, "R4 unsigned byte load");
      for (int k = 0; k < 2; k++)
         issue(4'd5, 32'h0000_4000, 12'(k), 32'd0, 32'h8001_7FFE, "R3 signed half load");
      for (int k = 0; k < 2; k++)
         issue(4'd9, 32'h0000_4000, 12'(k), 32'd0, 32'h8001_7FFE, "R4 unsigned half load");
      issue(4'd6, 32'h0000_5000, 12'h005, 32'd0, 32'h89AB_CDEF, "R4 R1 word load x4");
      issue(4'd6, 32'hFFFF_FFFC, 12'h002, 32'd0, 32'h0102_0304, "R1 address wraps");
      issue(4'd1, 32'h0000_1001, 12'h000, 32'h5555_AAAA, 32'd0, "R5 store half odd");
      issue(4'd9, 32'h0000_1003, 12'h000, 32'd0, 32'hFFFF_FFFF, "R5 load half odd");
      issue(4'd2, 32'h0000_1002, 12'h000, 32'h1111_2222, 32'd0, "R5 store word offset 2");
      issue(4'd6, 32'h0000_1001, 12'h004, 32'd0, 32'h3333_4444, "R5 load word offset 1");
      issue(4'd4, 32'h0000_1001, 12'h000, 32'd0, 32'h00C3_0000, "R5 byte at odd address legal");
      issue(4'd3, 32'h0000_1000, 12'h001, 32'h7777_7777, 32'd0, "R6 float store");
      issue(4'd7, 32'h0000_1003, 12'h001, 32'd0, 32'h7777_7777, "R6 float load priority");
      for (int op = 10; op < 16; op++)
         issue(4'(op), 32'h0000_1001, 12'h001, 32'hABCD_0123, 32'h0BAD_F00D, "R7 undefined op");

      repeat (10) @(negedge clk);
      chk(exp_q.size() == 0, "R8 all requests answered", 32'(exp_q.size()), 32'd0);
      chk(n_rsp == n_issued, "R8 busy requests ignored", 32'(n_rsp), 32'(n_issued));
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule